// File: doc/BRIEF.md
# Power-Fail Protected Static RAM

This block is a clocked model of an 8K x 8 static RAM that keeps its data while the main supply is absent. It sits behind an external voltage comparator that supplies two digital flags: one says the supply has dropped below the deselect threshold, and the other says it has fallen far enough that the battery has taken over. While either flag is raised, the memory ignores its bus entirely. It keeps every stored byte for as long as the battery phase lasts. After both flags clear, it stays locked for a fixed number of clock cycles before it accepts accesses again.

The host sees an asynchronous-style SRAM bus with active-low chip enable, output enable and write enable, sampled on the clock. The bidirectional data pin is split into an input bus, an output bus and an output-drive flag. A write is committed when its window closes, and a read returns data one cycle after the read condition is seen. A two-bit status output reports the supervisor state.

Top module: `pfs_sram`

## Requirements
- R1: The array stores 2^ADDR_W bytes (8192 by default). A byte written to an address is returned by a later read of that address, and every address is independent of the others.
- R2: At a clock edge where access is allowed, ce_n is 0 and we_n is 1, a read is performed. After that edge, drv_en is 1 only if oe_n was also 0, and rd_data then holds the addressed byte. At any time drv_en is 0, rd_data is 0.
- R3: The write window is open while ce_n and we_n are both 0. The byte is committed at the first edge where either of them is seen high, using the addr and wr_data present at that edge. A read that occurs at the same edge returns the newly committed byte.
- R4: we_n at 0 forces drv_en to 0 after that edge, even when ce_n and oe_n are 0.
- R5: While pf_desel is 1 (and pf_batt is 0), pwr_state is 1 after the edge, drv_en is 0, and no input changes the array.
- R6: If either fail flag rises while a write window is open, that write is dropped. The addressed byte keeps its old value, and so do all other bytes.
- R7: While pf_batt is 1, pwr_state is 2 and the array contents are kept for any number of cycles.
- R8: At the first edge where both flags are 0 after a deselected or battery state, pwr_state becomes 3 for exactly REC_CYCLES cycles and then becomes 0. During those cycles all accesses are ignored and drv_en stays 0. A fail flag seen during this time returns the block to state 1 or 2.
- R9: After synchronous reset, pwr_state is 0, drv_en is 0 and rd_data is 0.
- R10: When both flags are 1, pf_batt takes priority and pwr_state is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| wr_data | input | DATA_W | Write data |
| pf_desel | input | 1 | Supply below deselect threshold |
| pf_batt | input | 1 | Supply below battery switchover |
| rd_data | output | DATA_W | Read data, zero when not driven |
| drv_en | output | 1 | Stands for the data pin being driven |
| pwr_state | output | 2 | 0 normal, 1 deselected, 2 battery, 3 recovering |

## Verification
Directed patterns cover the following cases. A write closed by we_n rising while ce_n stays low separates write-first from read-first behaviour. A fail flag raised in the middle of a window separates an aborted write from a committed one. A long battery phase with random bus activity, followed by a recovery, shows both that the contents were kept and that accesses during the lockout were ignored. Random control, address and data traffic with occasional fail pulses then mixes reads, overlapping enables and aborted windows over a small address set, so that hits on recently written bytes happen often.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    PS_NORMAL = 2'd0,
    PS_DESEL  = 2'd1,
    PS_BATT   = 2'd2,
    PS_RECOV  = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int REC_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pf_desel,
  input  logic       pf_batt,
  output pwr_state_e state_q,
  output logic       access_ok
);
  localparam int CNT_W = (REC_CYCLES < 2) ? 1 : $clog2(REC_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REC_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // accesses pass only in the normal state with both flags low
  assign access_ok = (state_q == PS_NORMAL) && !pf_desel && !pf_batt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_NORMAL;
      cnt_q   <= '0;
    end else if (pf_batt) begin
      state_q <= PS_BATT;
    end else if (pf_desel) begin
      state_q <= PS_DESEL;
    end else begin
      case (state_q)
        PS_DESEL, PS_BATT: begin
          state_q <= PS_RECOV;
          cnt_q   <= CNT_LOAD;
        end
        PS_RECOV: begin
          if (cnt_q == '0) state_q <= PS_NORMAL;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= PS_NORMAL;
      endcase
    end
  end
endmodule

// File: rtl/pfs_access.sv
module pfs_access (
  input  logic clk,
  input  logic rst,
  input  logic access_ok,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_stb,
  output logic rd_stb,
  output logic drv_en_q
);
  logic win_q;

  // the window closes at the first edge that sees either enable high
  assign wr_stb = win_q && access_ok && (ce_n || we_n);
  assign rd_stb = access_ok && !ce_n && we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= 1'b0;
      drv_en_q <= 1'b0;
    end else begin
      // a window seen while access is blocked is dropped
      win_q    <= access_ok && !ce_n && !we_n;
      drv_en_q <= rd_stb && !oe_n;
    end
  end
endmodule

// File: rtl/pfs_array.sv
module pfs_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  // write-first read port on the shared address
  always_ff @(posedge clk) begin
    if (rd_en) begin
      if (wr_en) rdata_q <= wdata;
      else       rdata_q <= mem[addr];
    end
  end
endmodule

// File: rtl/pfs_sram.sv
module pfs_sram
  import pfs_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int REC_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pf_desel,
  input  logic              pf_batt,
  output logic [DATA_W-1:0] rd_data,
  output logic              drv_en,
  output logic [1:0]        pwr_state
);
  pwr_state_e        st;
  logic              ok;
  logic              wr_stb;
  logic              rd_stb;
  logic [DATA_W-1:0] arr_q;

  pfs_supervisor #(.REC_CYCLES(REC_CYCLES)) u_sup (
    .clk      (clk),
    .rst      (rst),
    .pf_desel (pf_desel),
    .pf_batt  (pf_batt),
    .state_q  (st),
    .access_ok(ok)
  );

  pfs_access u_acc (
    .clk      (clk),
    .rst      (rst),
    .access_ok(ok),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .drv_en_q (drv_en)
  );

  pfs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk    (clk),
    .wr_en  (wr_stb),
    .rd_en  (rd_stb),
    .addr   (addr),
    .wdata  (wr_data),
    .rdata_q(arr_q)
  );

  assign rd_data   = drv_en ? arr_q : '0;
  assign pwr_state = st;
endmodule

// File: rtl/pfs_sram_chk.sv
module pfs_sram_chk #(
  parameter int REC_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       ce_n,
  input logic       we_n,
  input logic       pf_desel,
  input logic       pf_batt,
  input logic       drv_en,
  input logic [1:0] pwr_state
);
  localparam int RW = $clog2(REC_CYCLES + 2);
  logic [RW-1:0] rec_run;

  always_ff @(posedge clk) begin
    if (rst)                     rec_run <= '0;
    else if (pwr_state == 2'd3)  rec_run <= rec_run + 1'b1;
    else                         rec_run <= '0;
  end

  a_r5_fail_no_drive: assert property (@(posedge clk) disable iff (rst)
    (pf_desel || pf_batt) |=> !drv_en);

  a_r4_we_low_no_drive: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !drv_en);

  a_r2_ce_high_no_drive: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !drv_en);

  a_r10_batt_state: assert property (@(posedge clk) disable iff (rst)
    pf_batt |=> (pwr_state == 2'd2));

  a_r5_desel_state: assert property (@(posedge clk) disable iff (rst)
    (pf_desel && !pf_batt) |=> (pwr_state == 2'd1));

  a_r8_enter_recov: assert property (@(posedge clk) disable iff (rst)
    ((pwr_state == 2'd1 || pwr_state == 2'd2) && !pf_desel && !pf_batt)
      |=> (pwr_state == 2'd3));

  a_r8_recov_blocked: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd3) |-> !drv_en);

  a_r8_recov_length: assert property (@(posedge clk) disable iff (rst)
    (pwr_state == 2'd3) |-> (rec_run < RW'(REC_CYCLES)));
endmodule

bind pfs_sram pfs_sram_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ce_n     (ce_n),
  .we_n     (we_n),
  .pf_desel (pf_desel),
  .pf_batt  (pf_batt),
  .drv_en   (drv_en),
  .pwr_state(pwr_state)
);

// File: tb/tb_pfs_sram.sv
`timescale 1ns/1ps
module tb_pfs_sram;
  localparam int AW  = 13;
  localparam int DW  = 8;
  localparam int REC = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst;
  logic ce_n, oe_n, we_n, pf_desel, pf_batt;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic drv_en;
  logic [1:0] pwr_state;

  always #2.5 clk = ~clk;

  pfs_sram #(.ADDR_W(AW), .DATA_W(DW), .REC_CYCLES(REC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wr_data(wr_data), .pf_desel(pf_desel), .pf_batt(pf_batt),
    .rd_data(rd_data), .drv_en(drv_en), .pwr_state(pwr_state)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  bit            known   [DEPTH];
  int            m_st, m_cnt;
  bit            m_win, m_en, m_qk;
  logic [DW-1:0] m_q;

  function automatic logic [AW-1:0] pick_addr(int unsigned r);
    return r[4] ? AW'(DEPTH - 16 + int'(r[3:0])) : AW'(r[3:0]);
  endfunction

  // reference model of one clock edge, taken from the requirements
  task automatic model_edge();
    bit ok;
    ok = (m_st == 0) && !pf_desel && !pf_batt;
    if (m_win && ok && (ce_n || we_n)) begin
      ref_mem[addr] = wr_data;
      known[addr]   = 1;
    end
    m_win = ok && !ce_n && !we_n;
    if (ok && !ce_n && we_n) begin
      m_q  = ref_mem[addr];
      m_qk = known[addr];
    end
    m_en = ok && !ce_n && !oe_n && we_n;
    if (pf_batt) m_st = 2;
    else if (pf_desel) m_st = 1;
    else if (m_st == 1 || m_st == 2) begin m_st = 3; m_cnt = REC - 1; end
    else if (m_st == 3) begin
      if (m_cnt == 0) m_st = 0; else m_cnt--;
    end
  endtask

  task automatic check_out(string tag);
    n_vec++;
    if (pwr_state !== 2'(m_st)) begin
      n_bad++;
      $display("FAIL %s pwr_state: got %0d expected %0d", tag, pwr_state, m_st);
    end else if (drv_en !== m_en) begin
      n_bad++;
      $display("FAIL %s drv_en: got %0b expected %0b", tag, drv_en, m_en);
    end else if (m_en && m_qk && rd_data !== m_q) begin
      n_bad++;
      $display("FAIL %s rd_data: got %02h expected %02h", tag, rd_data, m_q);
    end else if (!m_en && rd_data !== '0) begin
      n_bad++;
      $display("FAIL %s rd_data idle: got %02h expected 00", tag, rd_data);
    end
  endtask

  // drive at a falling edge, model the next rising edge, check at the next falling edge
  task automatic cyc(bit ce, bit oe, bit we, logic [AW-1:0] a, logic [DW-1:0] d,
                     bit vf, bit vb, string tag);
    ce_n = ce; oe_n = oe; we_n = we; addr = a; wr_data = d;
    pf_desel = vf; pf_batt = vb;
    model_edge();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    cyc(0, 1, 0, a, d, 0, 0, tag);
    cyc(1, 1, 1, a, d, 0, 0, tag);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    cyc(0, 0, 1, a, '0, 0, 0, tag);
    cyc(1, 1, 1, a, '0, 0, 0, tag);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin ref_mem[i] = '0; known[i] = 0; end
    m_st = 0; m_cnt = 0; m_win = 0; m_en = 0; m_qk = 0; m_q = '0;
    rst = 1; ce_n = 1; oe_n = 1; we_n = 1; addr = '0; wr_data = '0;
    pf_desel = 0; pf_batt = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check_out("R9");

    // preload the working address set
    for (int i = 0; i < 32; i++) begin
      r = $urandom;
      wr(pick_addr(i), DW'(r), "R1");
    end
    for (int i = 0; i < 32; i++) rd(pick_addr(i), "R1");

    // write closed by we_n rising while ce_n and oe_n stay low
    cyc(0, 0, 0, 13'd5, 8'hA5, 0, 0, "R4");
    cyc(0, 0, 1, 13'd5, 8'hA5, 0, 0, "R3");
    cyc(1, 1, 1, 13'd5, 8'h00, 0, 0, "R3");
    rd(13'd5, "R3");

    // fail flag in the middle of a window drops the write
    cyc(0, 1, 0, 13'd6, 8'h3C, 0, 0, "R6");
    cyc(0, 1, 0, 13'd6, 8'h3C, 1, 0, "R6");
    cyc(1, 1, 1, 13'd6, 8'h3C, 1, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 13'd7, 8'hFF, 1, 0, "R5");
    for (int i = 0; i < REC; i++) cyc(0, 0, 1, 13'd6, 8'h00, 0, 0, "R8");
    cyc(1, 1, 1, 13'd6, 8'h00, 0, 0, "R8");
    rd(13'd6, "R6");
    rd(13'd7, "R6");

    // long battery phase with bus activity
    for (int i = 0; i < 300; i++) begin
      r = $urandom;
      cyc(r[0], r[1], r[2], pick_addr(r >> 8), DW'(r >> 16), r[3], 1, "R10");
    end
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 13'd9, 8'h11, 1, 0, "R5");
    for (int i = 0; i < REC + 2; i++) begin
      r = $urandom;
      cyc(r[0], r[1], r[2], pick_addr(r >> 8), DW'(r >> 16), 0, 0, "R8");
    end
    cyc(1, 1, 1, '0, '0, 0, 0, "R8");
    for (int i = 0; i < 32; i++) rd(pick_addr(i), "R7");

    // recovery interrupted by a new failure
    cyc(1, 1, 1, '0, '0, 1, 0, "R5");
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, '0, '0, 0, 0, "R8");
    cyc(1, 1, 1, '0, '0, 0, 1, "R7");
    for (int i = 0; i < REC + 1; i++) cyc(1, 1, 1, '0, '0, 0, 0, "R8");

    // random traffic, address held while a window is open
    begin
      logic [AW-1:0] a_hold;
      a_hold = '0;
      for (int i = 0; i < 4000; i++) begin
        bit vf, vb;
        r = $urandom;
        if (!m_win) a_hold = pick_addr(r >> 8);
        vf = (r[31:26] == 6'd0);
        vb = (r[31:26] == 6'd1);
        cyc(r[0] & r[5], r[1], r[2], a_hold, DW'(r >> 16), vf, vb, "R2");
      end
    end
    for (int i = 0; i < REC + 2; i++) cyc(1, 1, 1, '0, '0, 0, 0, "R8");
    for (int i = 0; i < 32; i++) rd(pick_addr(i), "R1");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule